// File: doc/BRIEF.md
# Working Register Bank with Address Pointers

This block is the working register store of a small 8-bit processor core. It holds thirty-two byte-wide registers and serves them to the datapath in several shapes in the same cycle. There are two byte read ports that answer combinationally, one byte write port, one 16-bit pair read port and one 16-bit pair write port. Every write lands on the rising clock edge.

The six highest registers form three 16-bit address pointers. The pointer unit turns the selected pointer into a data address in one of three ways: with a displacement added, as a post-increment, or as a pre-decrement. The two stepping modes write the moved pointer back at the same clock edge as any other write.

A separate constant-load port can only reach the upper half of the file. An attempt to load a constant into the lower half is dropped and flagged. The bank also answers data-space byte accesses at addresses 0x00 to 0x1F, so software can read and write the registers as memory. When several writers target one register in the same cycle, a fixed priority decides which one wins.

Top module: `wreg_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, every register reads 0x00 and `imm_err` is low.
- R2: `rd_a_data` and `rd_b_data` show the register named by `rd_a_idx` and `rd_b_idx` in the same cycle. A read of a register that is being written in that cycle returns the old value. The new value is visible after the edge.
- R3: With `wr_en` high, `wr_data` is stored into register `wr_idx` at the clock edge.
- R4: `pair_rd_data` equals {R(2p+1), R(2p)} for p = `pair_rd_idx`. With `pair_wr_en` high, `pair_wr_data[7:0]` goes to R(2p) and `pair_wr_data[15:8]` goes to R(2p+1) for p = `pair_wr_idx`.
- R5: `ptr_sel` picks the pointer: 0 is R27:R26, 1 is R29:R28 and 2 is R31:R30, with the lower-numbered register as the low byte. Code 3 is reserved: `ptr_addr` is 0x0000 and no register is written back.
- R6: `ptr_mode` 0 (displacement) and 3 (plain) drive `ptr_addr` = pointer + zero-extended `ptr_disp`, modulo 2^16, and never modify the pointer.
- R7: `ptr_mode` 1 (post-increment) drives `ptr_addr` = pointer. When `ptr_en` is high, pointer + 1 (mod 2^16) is written back.
- R8: `ptr_mode` 2 (pre-decrement) drives `ptr_addr` = pointer − 1 (mod 2^16). When `ptr_en` is high, that value is written back.
- R9: A constant load (`imm_en`) into R16..R31 stores `imm_data`. A constant load into R0..R15 changes no register.
- R10: `imm_err` is high for exactly the one cycle after a constant load aimed at R0..R15, and low otherwise.
- R11: With `mem_en` high and `mem_addr` below 0x20, `mem_hit` is 1 and `mem_rdata` is R[`mem_addr`]. If `mem_we` is also high, `mem_wdata` is stored there. At any other address, `mem_hit` is 0, `mem_rdata` is 0x00 and nothing is written.
- R12: When several writers target the same register in one cycle, the winner is chosen in this order, highest first: pointer writeback, pair write, byte write, constant load, data-space write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pair_rd_idx | input | 4 | Pair read index p |
| pair_rd_data | output | 16 | Pair read data |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_idx | input | 4 | Pair write index p |
| pair_wr_data | input | 16 | Pair write data |
| imm_en | input | 1 | Constant load enable |
| imm_idx | input | 5 | Constant load register index |
| imm_data | input | 8 | Constant value |
| imm_err | output | 1 | Rejected constant load strobe |
| ptr_en | input | 1 | Pointer writeback enable |
| ptr_sel | input | 2 | Pointer select |
| ptr_mode | input | 2 | Pointer addressing mode |
| ptr_disp | input | 6 | Displacement |
| ptr_addr | output | 16 | Computed data address |
| mem_en | input | 1 | Data-space access enable |
| mem_we | input | 1 | Data-space write |
| mem_addr | input | 16 | Data-space byte address |
| mem_wdata | input | 8 | Data-space write data |
| mem_hit | output | 1 | Address falls on the register window |
| mem_rdata | output | 8 | Data-space read data |

## Verification
The bench builds the block with its defaults: 32 registers of 8 bits, constant loads allowed from R16 up, and a 6-bit displacement. With these values a single pair write of 0xFFFF or 0x0000 puts the 16-bit wrap of both stepping modes one cycle away. Random data-space addresses drawn from 0 to 47 hit both sides of the 0x20 window edge. A 5-bit random constant index lands in the forbidden lower half about half the time, so the error strobe is exercised often.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  typedef enum logic [1:0] {
    PM_DISP    = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_PLAIN   = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/wreg_rd_mux.sv
module wreg_rd_mux #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][DW-1:0] regs,
  input  logic [IDX_W-1:0]         idx,
  output logic [DW-1:0]            data
);
  // Pure combinational select; reads always see pre-edge contents.
  assign data = regs[idx];
endmodule

// File: rtl/wreg_ptr_unit.sv
module wreg_ptr_unit #(
  parameter int AW       = 16,
  parameter int DISP_W   = 6,
  parameter int IDX_W    = 5,
  parameter int PTR_BASE = 26
) (
  input  logic              en,
  input  logic [1:0]        sel,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     cur,
  output logic [AW-1:0]     addr,
  output logic              upd_en,
  output logic [AW-1:0]     upd_val,
  output logic [IDX_W-1:0]  lo_idx
);
  import wreg_pkg::*;

  logic valid;
  assign valid  = (sel != PS_NONE);
  assign lo_idx = IDX_W'(PTR_BASE + 2 * int'(sel));

  always_comb begin
    upd_en  = 1'b0;
    upd_val = cur;
    addr    = cur + AW'(disp);
    unique case (ptr_mode_e'(mode))
      PM_POSTINC: begin
        addr    = cur;
        upd_val = cur + AW'(1);
        upd_en  = en;
      end
      PM_PREDEC: begin
        upd_val = cur - AW'(1);
        addr    = cur - AW'(1);
        upd_en  = en;
      end
      default: ;
    endcase
    if (!valid) begin
      addr   = '0;
      upd_en = 1'b0;
    end
  end
endmodule

// File: rtl/wreg_write_merge.sv
module wreg_write_merge #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][DW-1:0] cur,
  input  logic                     byte_en,
  input  logic [IDX_W-1:0]         byte_idx,
  input  logic [DW-1:0]            byte_data,
  input  logic                     imm_en,
  input  logic [IDX_W-1:0]         imm_idx,
  input  logic [DW-1:0]            imm_data,
  input  logic                     mem_en,
  input  logic [IDX_W-1:0]         mem_idx,
  input  logic [DW-1:0]            mem_data,
  input  logic                     wide_en,
  input  logic [IDX_W-2:0]         wide_pair,
  input  logic [2*DW-1:0]          wide_data,
  input  logic                     ptr_en,
  input  logic [IDX_W-1:0]         ptr_lo,
  input  logic [2*DW-1:0]          ptr_val,
  output logic [NREGS-1:0][DW-1:0] nxt
);
  // Each register resolves its own writers; later tests override
  // earlier ones, so the lowest-priority source is applied first.
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam int EVN = i - (i % 2);
    localparam bit HI  = (i % 2) == 1;
    logic [DW-1:0] v;
    always_comb begin
      v = cur[i];
      if (mem_en  && mem_idx  == IDX_W'(i)) v = mem_data;
      if (imm_en  && imm_idx  == IDX_W'(i)) v = imm_data;
      if (byte_en && byte_idx == IDX_W'(i)) v = byte_data;
      if (wide_en && wide_pair == (IDX_W-1)'(i / 2))
        v = HI ? wide_data[2*DW-1:DW] : wide_data[DW-1:0];
      if (ptr_en && ptr_lo == IDX_W'(EVN))
        v = HI ? ptr_val[2*DW-1:DW] : ptr_val[DW-1:0];
    end
    assign nxt[i] = v;
  end
endmodule

// File: rtl/wreg_bank.sv
module wreg_bank #(
  parameter int NREGS    = 32,
  parameter int DW       = 8,
  parameter int IMM_BASE = 16,
  parameter int DISP_W   = 6,
  parameter int PTR_BASE = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_a_idx,
  output logic [7:0]  rd_a_data,
  input  logic [4:0]  rd_b_idx,
  output logic [7:0]  rd_b_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  pair_rd_idx,
  output logic [15:0] pair_rd_data,
  input  logic        pair_wr_en,
  input  logic [3:0]  pair_wr_idx,
  input  logic [15:0] pair_wr_data,
  input  logic        imm_en,
  input  logic [4:0]  imm_idx,
  input  logic [7:0]  imm_data,
  output logic        imm_err,
  input  logic        ptr_en,
  input  logic [1:0]  ptr_sel,
  input  logic [1:0]  ptr_mode,
  input  logic [5:0]  ptr_disp,
  output logic [15:0] ptr_addr,
  input  logic        mem_en,
  input  logic        mem_we,
  input  logic [15:0] mem_addr,
  input  logic [7:0]  mem_wdata,
  output logic        mem_hit,
  output logic [7:0]  mem_rdata
);
  import wreg_pkg::*;

  localparam int IDX_W = $clog2(NREGS);
  localparam int AW    = 2 * DW;
  localparam int NPTR  = 3;

  logic [NREGS-1:0][DW-1:0] regs, regs_nxt;
  logic [AW-1:0]            ptr_view [4];
  logic [AW-1:0]            ptr_cur, ptr_upd_val;
  logic                     ptr_upd_en;
  logic [IDX_W-1:0]         ptr_lo;
  logic                     imm_low, imm_ok, mem_wr_ok;
  logic [DW-1:0]            mem_rd;

  // Pointer views over the top register pairs
  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign ptr_view[k] = {regs[PTR_BASE + 2*k + 1], regs[PTR_BASE + 2*k]};
  end
  assign ptr_view[3] = '0;
  assign ptr_cur     = ptr_view[ptr_sel];

  wreg_ptr_unit #(.AW(AW), .DISP_W(DISP_W), .IDX_W(IDX_W), .PTR_BASE(PTR_BASE)) u_ptr (
    .en(ptr_en), .sel(ptr_sel), .mode(ptr_mode), .disp(ptr_disp), .cur(ptr_cur),
    .addr(ptr_addr), .upd_en(ptr_upd_en), .upd_val(ptr_upd_val), .lo_idx(ptr_lo)
  );

  // Read side
  wreg_rd_mux #(.NREGS(NREGS), .DW(DW), .IDX_W(IDX_W)) u_rd_a (
    .regs(regs), .idx(rd_a_idx), .data(rd_a_data));
  wreg_rd_mux #(.NREGS(NREGS), .DW(DW), .IDX_W(IDX_W)) u_rd_b (
    .regs(regs), .idx(rd_b_idx), .data(rd_b_data));
  wreg_rd_mux #(.NREGS(NREGS), .DW(DW), .IDX_W(IDX_W)) u_rd_m (
    .regs(regs), .idx(mem_addr[IDX_W-1:0]), .data(mem_rd));

  assign pair_rd_data = {regs[{pair_rd_idx, 1'b1}], regs[{pair_rd_idx, 1'b0}]};

  assign mem_hit   = mem_en && (mem_addr < AW'(NREGS));
  assign mem_rdata = mem_hit ? mem_rd : '0;
  assign mem_wr_ok = mem_hit && mem_we;

  assign imm_low = imm_en && (imm_idx < IDX_W'(IMM_BASE));
  assign imm_ok  = imm_en && !imm_low;

  wreg_write_merge #(.NREGS(NREGS), .DW(DW), .IDX_W(IDX_W)) u_merge (
    .cur(regs),
    .byte_en(wr_en), .byte_idx(wr_idx), .byte_data(wr_data),
    .imm_en(imm_ok), .imm_idx(imm_idx), .imm_data(imm_data),
    .mem_en(mem_wr_ok), .mem_idx(mem_addr[IDX_W-1:0]), .mem_data(mem_wdata),
    .wide_en(pair_wr_en), .wide_pair(pair_wr_idx), .wide_data(pair_wr_data),
    .ptr_en(ptr_upd_en), .ptr_lo(ptr_lo), .ptr_val(ptr_upd_val),
    .nxt(regs_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs    <= '0;
      imm_err <= 1'b0;
    end else begin
      regs    <= regs_nxt;
      imm_err <= imm_low;
    end
  end

  // Checks beside the logic they guard
  p_imm_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    imm_en && imm_idx < IDX_W'(IMM_BASE) |=> imm_err);
  p_imm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_en && imm_idx < IDX_W'(IMM_BASE)) |=> !imm_err);
  p_postinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_en && ptr_sel != PS_NONE && ptr_mode == PM_POSTINC
      |=> ptr_view[$past(ptr_sel)] == $past(ptr_addr) + AW'(1));
  p_predec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_en && ptr_sel != PS_NONE && ptr_mode == PM_PREDEC
      |=> ptr_view[$past(ptr_sel)] == $past(ptr_addr));
  p_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_addr >= AW'(NREGS) |-> !mem_hit && mem_rdata == '0);
endmodule

// File: tb/wreg_bank_tb.sv
`timescale 1ns/1ps
module wreg_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, imm_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, imm_data, mem_wdata, mem_rdata;
  logic        wr_en, pair_wr_en, imm_en, imm_err, ptr_en, mem_en, mem_we, mem_hit;
  logic [3:0]  pair_rd_idx, pair_wr_idx;
  logic [15:0] pair_rd_data, pair_wr_data, ptr_addr, mem_addr;
  logic [1:0]  ptr_sel, ptr_mode;
  logic [5:0]  ptr_disp;

  wreg_bank dut_i (.*);

  int m [32];
  int exp_err = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ptr_of(int s);
    return (m[26 + 2*s + 1] << 8) | m[26 + 2*s];
  endfunction

  function automatic int exp_addr();
    int p;
    if (ptr_sel == 2'd3) return 0;
    p = ptr_of(ptr_sel);
    if (ptr_mode == 2'd1) return p;
    if (ptr_mode == 2'd2) return (p - 1) & 16'hFFFF;
    return (p + ptr_disp) & 16'hFFFF;
  endfunction

  task automatic compare_all();
    bit hit;
    string ptag;
    chk("R2 rd_a", rd_a_data, m[rd_a_idx]);
    chk("R2 rd_b", rd_b_data, m[rd_b_idx]);
    chk("R4 pair_rd", pair_rd_data, (m[2*pair_rd_idx+1] << 8) | m[2*pair_rd_idx]);
    ptag = (ptr_sel == 2'd3) ? "R5 ptr_addr" : (ptr_mode == 2'd1) ? "R7 ptr_addr" :
           (ptr_mode == 2'd2) ? "R8 ptr_addr" : "R6 ptr_addr";
    chk(ptag, ptr_addr, exp_addr());
    hit = mem_en && (mem_addr < 16'd32);
    chk("R11 mem_hit", mem_hit, hit);
    chk("R11 mem_rdata", mem_rdata, hit ? m[mem_addr[4:0]] : 0);
    chk("R10 imm_err", imm_err, exp_err);
  endtask

  // Behavioural update: lowest priority applied first (R12)
  task automatic commit();
    int nm [32];
    int p;
    nm = m;
    if (mem_en && mem_we && mem_addr < 16'd32) nm[mem_addr[4:0]] = mem_wdata;
    if (imm_en && imm_idx >= 5'd16) nm[imm_idx] = imm_data;
    if (wr_en) nm[wr_idx] = wr_data;
    if (pair_wr_en) begin
      nm[2*pair_wr_idx]   = pair_wr_data[7:0];
      nm[2*pair_wr_idx+1] = pair_wr_data[15:8];
    end
    if (ptr_en && ptr_sel != 2'd3 && (ptr_mode == 2'd1 || ptr_mode == 2'd2)) begin
      p = ptr_of(ptr_sel);
      p = (ptr_mode == 2'd1) ? ((p + 1) & 16'hFFFF) : ((p - 1) & 16'hFFFF);
      nm[26 + 2*ptr_sel]     = p & 8'hFF;
      nm[26 + 2*ptr_sel + 1] = p >> 8;
    end
    exp_err = (imm_en && imm_idx < 5'd16) ? 1 : 0;
    m = nm;
  endtask

  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    commit();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pair_wr_en = 0; imm_en = 0; ptr_en = 0; mem_en = 0; mem_we = 0;
    ptr_sel = 2'd3; ptr_mode = 2'd0; ptr_disp = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (m[i]) m[i] = 0;
    idle();
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; imm_idx = 0; imm_data = 0;
    pair_rd_idx = 0; pair_wr_idx = 0; pair_wr_data = 0; mem_addr = 0; mem_wdata = 0;
    // R1: reset state
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i);
      #1 chk("R1 reset value", rd_a_data, 0);
    end
    chk("R1 imm_err in reset", imm_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 byte write, R2 same-cycle read sees old value
    wr_en = 1; wr_idx = 5; wr_data = 8'h3C; rd_a_idx = 5;
    #1 chk("R2 old value during write", rd_a_data, 0);
    cyc(); idle();
    #1 chk("R3 byte write stored", rd_a_data, 8'h3C);

    // R9 constant loads, R10 strobe
    imm_en = 1; imm_idx = 20; imm_data = 8'hA5; cyc();
    imm_idx = 3; imm_data = 8'h77; cyc(); idle();
    rd_a_idx = 20; rd_b_idx = 3;
    #1 chk("R9 upper half loaded", rd_a_data, 8'hA5);
    chk("R9 lower half untouched", rd_b_data, 0);
    chk("R10 strobe after reject", imm_err, 1);
    cyc();
    chk("R10 strobe one cycle", imm_err, 0);

    // R4 pair write of pointer X to 0xFFFF
    pair_wr_en = 1; pair_wr_idx = 13; pair_wr_data = 16'hFFFF; cyc(); idle();
    pair_rd_idx = 13;
    #1 chk("R4 pair readback", pair_rd_data, 16'hFFFF);

    // R7 post-increment wraps
    ptr_en = 1; ptr_sel = 0; ptr_mode = 1;
    #1 chk("R7 address is old pointer", ptr_addr, 16'hFFFF);
    cyc(); idle();
    #1 chk("R7 wrapped to zero", pair_rd_data, 0);

    // R8 pre-decrement wraps
    ptr_en = 1; ptr_sel = 1; ptr_mode = 2;
    #1 chk("R8 address is pointer-1", ptr_addr, 16'hFFFF);
    cyc(); idle();
    pair_rd_idx = 14;
    #1 chk("R8 writeback", pair_rd_data, 16'hFFFF);

    // R6 displacement does not move pointer
    pair_wr_en = 1; pair_wr_idx = 15; pair_wr_data = 16'h1234; cyc(); idle();
    ptr_en = 1; ptr_sel = 2; ptr_mode = 0; ptr_disp = 6'h3F;
    #1 chk("R6 displaced address", ptr_addr, 16'h1273);
    cyc(); idle();
    pair_rd_idx = 15;
    #1 chk("R6 pointer unchanged", pair_rd_data, 16'h1234);

    // R5 reserved select
    ptr_en = 1; ptr_sel = 3; ptr_mode = 1;
    #1 chk("R5 reserved address", ptr_addr, 0);
    cyc(); idle();
    for (int p = 13; p < 16; p++) begin
      pair_rd_idx = 4'(p);
      #1 chk("R5 no writeback", pair_rd_data, (m[2*p+1] << 8) | m[2*p]);
    end
    pair_rd_idx = 15;
    #1 chk("R5 Z kept", pair_rd_data, 16'h1234);

    // R11 data-space alias
    mem_en = 1; mem_we = 1; mem_addr = 16'h0007; mem_wdata = 8'h99; cyc();
    mem_we = 0;
    #1 chk("R11 alias readback", mem_rdata, 8'h99);
    mem_we = 1; mem_addr = 16'h0020; mem_wdata = 8'h55; cyc(); idle();
    rd_a_idx = 0;
    #1 chk("R11 out-of-window write ignored", rd_a_data, 0);

    // R12 priority
    ptr_en = 1; ptr_sel = 0; ptr_mode = 1;
    pair_wr_en = 1; pair_wr_idx = 13; pair_wr_data = 16'hBEEF;
    wr_en = 1; wr_idx = 26; wr_data = 8'h11;
    imm_en = 1; imm_idx = 27; imm_data = 8'h22;
    mem_en = 1; mem_we = 1; mem_addr = 16'h001A; mem_wdata = 8'h33;
    cyc(); idle();
    pair_rd_idx = 13;
    #1 chk("R12 pointer wins", pair_rd_data, 16'h0001);
    wr_en = 1; wr_idx = 10; wr_data = 8'h44;
    mem_en = 1; mem_we = 1; mem_addr = 16'h000A; mem_wdata = 8'h55;
    cyc(); idle();
    wr_en = 1; wr_idx = 17; wr_data = 8'h66; imm_en = 1; imm_idx = 17; imm_data = 8'h77;
    cyc(); idle();
    wr_en = 1; wr_idx = 16; wr_data = 8'h88;
    pair_wr_en = 1; pair_wr_idx = 8; pair_wr_data = 16'hC0DE;
    cyc(); idle();
    rd_a_idx = 10; rd_b_idx = 17; pair_rd_idx = 8;
    #1 chk("R12 byte over data-space", rd_a_data, 8'h44);
    chk("R12 pair over byte", pair_rd_data, 16'hC0DE);
    cyc();

    wr_en = 1; wr_idx = 17; wr_data = 8'h66; imm_en = 1; imm_idx = 17; imm_data = 8'h77;
    pair_wr_en = 0;
    cyc(); idle();
    rd_b_idx = 17;
    #1 chk("R12 byte over constant", rd_b_data, 8'h66);

    // Random traffic checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom); pair_rd_idx = 4'($urandom);
      wr_en = ($urandom_range(0, 2) == 0); wr_idx = 5'($urandom); wr_data = 8'($urandom);
      pair_wr_en = ($urandom_range(0, 5) == 0); pair_wr_idx = 4'($urandom_range(12, 15));
      pair_wr_data = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      imm_en = ($urandom_range(0, 2) == 0); imm_idx = 5'($urandom); imm_data = 8'($urandom);
      ptr_en = $urandom_range(0, 1); ptr_sel = 2'($urandom); ptr_mode = 2'($urandom);
      ptr_disp = 6'($urandom);
      mem_en = $urandom_range(0, 1); mem_we = $urandom_range(0, 1);
      mem_addr = 16'($urandom_range(0, 47)); mem_wdata = 8'($urandom);
      cyc();
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule